// File: doc/BRIEF.md
# Periodic Real-Time Clock Register Block

This block holds a set of calendar fields (seconds, minutes, hours, weekday, day of month, month and year) behind a two-port host window. The host first writes a register number to the index port. Each later access to the data port then reads or writes the register that number selects. A free-running divider produces a one-cycle interrupt pulse every `TICK_CYCLES` clocks. A 10-bit pulse counter advances the seconds field once every 1024 pulses.

Three status registers return fixed codes, with one live bit in the first of them. A fourth status number and every unassigned number are illegal: any data-port access to them raises an error pulse. Month and year are stored in an internal form and converted on every access. Month is kept zero-based, and year is kept with an offset of 52.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, the seconds, minutes, hours, weekday and day-of-month registers read 0, month reads 1, year reads 204 (0 minus 52, modulo 256), the index reads 0, and `irq`, `err` and `rvalid` are low.
- R2: `irq` is high for exactly one cycle, and consecutive pulses are exactly `TICK_CYCLES` clocks apart.
- R3: Seconds change only by a host write or on the 1024th pulse of each group of 1024 pulses counted from reset. On that pulse the value goes up by one, and 59 wraps to 0.
- R4: A write with `sel_data`=0 loads the index from `wdata`. A read with `sel_data`=0 returns the index. Every read (`rd_en`=1) gives `rvalid`=1 with `rdata` in the following cycle.
- R5: Register numbers 0x00 (seconds), 0x01 (minutes), 0x02 (hours), 0x03 (weekday) and 0x04 (day of month) read back exactly the byte last written through the data port.
- R6: Register 0x05 (month) stores the written value minus 1 and reads the stored value plus 1, so a written value reads back unchanged.
- R7: Register 0x06 (year) stores the written value plus 52 and reads the stored value minus 52, modulo 256.
- R8: Register 0x0A (status A) reads 0x26, with bit 7 set while the pulse counter holds 1023. Over any 1024×`TICK_CYCLES` consecutive cycles it reads 0xA6 in exactly `TICK_CYCLES` cycles.
- R9: Register 0x0B reads 0x46 and 0x0C reads 0x00. Data writes to 0x0A, 0x0B and 0x0C have no effect.
- R10: A data-port access with the index at 0x0D or at any number not listed above sets `err` high for one cycle, in the cycle after the access. Such a read returns 0x00, and such a write changes no register.
- R11: A host write to seconds at the same clock edge as a seconds increment wins: the written value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq | output | 1 | Periodic interrupt pulse |
| err | output | 1 | Illegal register access pulse |

## Verification
A host write to the seconds register and the internal seconds increment can land on the same clock edge. The bench counts interrupt pulses at the ports. When it sees the pulse that closes a group of 1024, it drives a seconds write into that same edge and then reads the field back. The value read must be the one written, not the incremented value. The status-A burst checks the other timing-dependent path: `TICK_CYCLES` reads of 0xA6 across one full group of pulses.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int TICK_CYCLES = 32,
  parameter int SUB_BITS    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_data,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rvalid,
  output logic       irq,
  output logic       err
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_CYCLES - 1);
  localparam logic [7:0] YEAR_OFS = 8'd52;

  localparam logic [7:0] I_SEC  = 8'h00;
  localparam logic [7:0] I_MIN  = 8'h01;
  localparam logic [7:0] I_HOUR = 8'h02;
  localparam logic [7:0] I_WDAY = 8'h03;
  localparam logic [7:0] I_MDAY = 8'h04;
  localparam logic [7:0] I_MON  = 8'h05;
  localparam logic [7:0] I_YEAR = 8'h06;
  localparam logic [7:0] I_STA  = 8'h0A;
  localparam logic [7:0] I_STB  = 8'h0B;
  localparam logic [7:0] I_STC  = 8'h0C;

  logic [7:0] idx_q, sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
  logic [TW-1:0] tick_q;
  logic [SUB_BITS-1:0] sub_q;
  logic irq_q, rvalid_q, err_q;
  logic [7:0] rdata_q, rd_mux;
  logic known;

  wire uip      = &sub_q;
  wire sec_step = irq_q && uip;
  wire dwr      = wr_en && sel_data;
  wire drd      = rd_en && sel_data;
  wire [7:0] sec_inc = (sec_q == 8'd59) ? 8'd0 : sec_q + 8'd1;

  always_comb begin
    known  = 1'b1;
    rd_mux = 8'h00;
    case (idx_q)
      I_SEC:  rd_mux = sec_q;
      I_MIN:  rd_mux = min_q;
      I_HOUR: rd_mux = hour_q;
      I_WDAY: rd_mux = wday_q;
      I_MDAY: rd_mux = mday_q;
      I_MON:  rd_mux = mon_q + 8'd1;
      I_YEAR: rd_mux = year_q - YEAR_OFS;
      I_STA:  rd_mux = {uip, 7'h26};
      I_STB:  rd_mux = 8'h46;
      I_STC:  rd_mux = 8'h00;
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      irq_q  <= 1'b0;
      sub_q  <= '0;
    end else begin
      tick_q <= (tick_q == TLAST) ? '0 : tick_q + 1'b1;
      irq_q  <= (tick_q == TLAST);
      if (irq_q) sub_q <= sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; sec_q <= '0; min_q <= '0; hour_q <= '0;
      wday_q <= '0; mday_q <= '0; mon_q <= '0; year_q <= '0;
    end else begin
      if (wr_en && !sel_data) idx_q <= wdata;
      if (dwr && idx_q == I_SEC) sec_q <= wdata;
      else if (sec_step)         sec_q <= sec_inc;
      if (dwr) begin
        case (idx_q)
          I_MIN:  min_q  <= wdata;
          I_HOUR: hour_q <= wdata;
          I_WDAY: wday_q <= wdata;
          I_MDAY: mday_q <= wdata;
          I_MON:  mon_q  <= wdata - 8'd1;
          I_YEAR: year_q <= wdata + YEAR_OFS;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= sel_data ? rd_mux : idx_q;
      err_q    <= (dwr || drd) && !known;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign irq    = irq_q;
  assign err    = err_q;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_data,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       rvalid,
  input logic       irq,
  input logic       err,
  input logic [7:0] idx,
  input logic [7:0] sec
);
  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_rvalid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  p_rvalid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  p_sec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq) && !$past(wr_en)) |-> $stable(sec));

  p_err_needs_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(sel_data && (rd_en || wr_en)));

  p_statb_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(rd_en && sel_data && idx == 8'h0B)) |-> rdata == 8'h46);
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .rvalid(rvalid), .irq(irq), .err(err), .idx(idx_q), .sec(sec_q)
);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
  localparam int TICK = 2;
  localparam int GROUP = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_data = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rvalid, irq, err;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit burst = 1'b0;
  int burst_hi = 0, burst_n = 0;
  int pulses = 0;
  logic irq_s = 1'b0;
  int cyc = 0, last_pulse = -1, spacing_bad = 0, width_bad = 0;
  logic irq_prev = 1'b0;

  always #10 clk = ~clk;

  rtc_regfile #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq), .err(err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rvalid) begin
      if (burst) begin
        burst_n++;
        if (rdata == 8'hA6) burst_hi++;
        else if (rdata != 8'h26) check("R8 status A value", rdata, 8'h26);
      end else if (exp_q.size() == 0) begin
        check("R4 unexpected rvalid", 1, 0);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    irq_s <= irq;
    if (rst_n) begin
      cyc <= cyc + 1;
      if (irq && irq_prev) width_bad <= width_bad + 1;
      if (irq && !irq_prev) begin
        if (last_pulse >= 0 && cyc - last_pulse != TICK) spacing_bad <= spacing_bad + 1;
        last_pulse <= cyc;
      end
      irq_prev <= irq;
    end
  end

  always @(posedge clk) if (!rst_n) pulses <= 0; else if (irq_s) pulses <= pulses + 1;

  task automatic set_index(input logic [7:0] i);
    @(negedge clk); sel_data = 1'b0; wr_en = 1'b1; wdata = i;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); sel_data = 1'b1; wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_port(input logic sel, input logic [7:0] exp, input string tag);
    @(negedge clk); sel_data = sel; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, input logic [7:0] exp, input string tag);
    set_index(i); rd_port(1'b1, exp, tag);
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    set_index(i); wr_data(d);
  endtask

  task automatic wait_group_end;
    int tgt;
    tgt = ((pulses / GROUP) + 1) * GROUP;
    while (pulses < tgt) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err after reset", err, 0);
    check("R1 rvalid after reset", rvalid, 0);
    rd_port(1'b0, 8'h00, "R1 index");
    rd_reg(8'h00, 8'h00, "R1 seconds");
    rd_reg(8'h03, 8'h00, "R1 weekday");
    rd_reg(8'h05, 8'h01, "R1 month");
    rd_reg(8'h06, 8'd204, "R1 year");
    rd_reg(8'h0A, 8'h26, "R8 status A early");
    rd_reg(8'h0B, 8'h46, "R9 status B");
    rd_reg(8'h0C, 8'h00, "R9 status C");

    set_index(8'h04);
    rd_port(1'b0, 8'h04, "R4 index readback");
    wr_reg(8'h01, 8'd45); rd_reg(8'h01, 8'd45, "R5 minutes");
    wr_reg(8'h02, 8'd23); rd_reg(8'h02, 8'd23, "R5 hours");
    wr_reg(8'h03, 8'd6);  rd_reg(8'h03, 8'd6,  "R5 weekday");
    wr_reg(8'h04, 8'd31); rd_reg(8'h04, 8'd31, "R5 mday");
    wr_reg(8'h05, 8'd12); rd_reg(8'h05, 8'd12, "R6 month");
    wr_reg(8'h05, 8'd0);  rd_reg(8'h05, 8'd0,  "R6 month zero");
    wr_reg(8'h06, 8'd99); rd_reg(8'h06, 8'd99, "R7 year");
    wr_reg(8'h06, 8'd210); rd_reg(8'h06, 8'd210, "R7 year wrap");

    wr_reg(8'h0B, 8'h00); rd_reg(8'h0B, 8'h46, "R9 status B after write");
    wr_reg(8'h0C, 8'hFF); rd_reg(8'h0C, 8'h00, "R9 status C after write");

    set_index(8'h0D);
    rd_port(1'b1, 8'h00, "R10 reg D read data");
    check("R10 err after D read", err, 1);
    @(negedge clk);
    check("R10 err one cycle", err, 0);
    set_index(8'h20);
    wr_data(8'h55);
    check("R10 err after unknown write", err, 1);
    rd_reg(8'h01, 8'd45, "R10 minutes untouched");
    rd_reg(8'h04, 8'd31, "R10 mday untouched");

    set_index(8'h0A);
    @(negedge clk);
    burst = 1'b1; sel_data = 1'b1; rd_en = 1'b1;
    repeat (GROUP * TICK) @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    burst = 1'b0;
    check("R8 status A burst count", burst_n, GROUP * TICK);
    check("R8 uip reads per group", burst_hi, TICK);

    wr_reg(8'h00, 8'd59);
    wait_group_end;
    rd_reg(8'h00, 8'd0, "R3 seconds wrap 59 to 0");
    wr_reg(8'h00, 8'd7);
    wait_group_end;
    rd_reg(8'h00, 8'd8, "R3 seconds step");

    set_index(8'h00);
    sel_data = 1'b1;
    @(negedge clk);
    while (!(irq && (pulses % GROUP) == GROUP - 1)) @(negedge clk);
    wr_en = 1'b1; wdata = 8'd33;
    @(negedge clk); wr_en = 1'b0;
    rd_port(1'b1, 8'd33, "R11 write beats increment");

    repeat (4) @(negedge clk);
    check("R2 irq spacing errors", spacing_bad, 0);
    check("R2 irq width errors", width_bad, 0);
    check("R2 pulses seen", (pulses > 3 * GROUP) ? 1 : 0, 1);
    check("R4 pending reads", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule